// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is one countdown timer on a small 32-bit register bus. Software programs a reload value, picks a counter size of 16 or 32 bits, a clock divider (1, 16 or 256) and one of three counting behaviours, then sets the enable bit. Each time the divided tick arrives, the count drops by one. When the count reaches zero, a sticky status flag is set. The flag drives a single level interrupt through an enable mask, and software clears it by writing a dedicated clear word.

Two mode bits select the counting behaviour. With both clear, the count wraps to the largest value of the selected size. With the periodic bit set, the count reloads from the programmed reload value. With the one-shot bit set, the count stops at zero. The reload value can be written in two ways. The immediate port also restarts the count. The deferred port only changes what the next wrap reloads.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control word reads 0x20 (interrupt enable set, timer disabled). The count, the reload value and the raw flag read 0, and `irq` is low.
- R2: The control word (word offset 2) holds bits [7:0]: bit0 one-shot, bit1 wide (32-bit) count, bits[3:2] divider select, bit5 interrupt enable, bit6 periodic, bit7 enable. It reads back those 8 bits with bits [31:8] zero.
- R3: Divider select 00 ticks every cycle, 01 every 16 cycles and 10 every 256 cycles; 11 behaves as 00. The divider restarts from zero on every control write and while enable is clear, so the first tick comes a full divider period after the control write.
- R4: The count drops by one per tick and holds while enable is clear.
- R5: With both mode bits clear, a tick at zero loads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R6: With the periodic bit set (one-shot clear), a tick at zero loads the reload value.
- R7: With the one-shot bit set, the count stays at zero on later ticks until software reloads it.
- R8: A write to offset 0 stores the reload value and sets the count to it at the same edge. This write takes priority over a tick in the same cycle.
- R9: A write to offset 6 stores the reload value and leaves the count unchanged. Reads of offset 0 and offset 6 both return the stored reload value.
- R10: A tick that moves the count from 1 to 0 sets the raw flag. Any write to offset 3 clears the flag. If both happen in the same cycle, the flag stays set.
- R11: Offset 4 reads the raw flag in bit 0. Offset 5 and `irq` both equal the raw flag AND the interrupt-enable bit.
- R12: In 16-bit mode only the low 16 bits of the count are used. Offset 1 reads the count with bits [31:16] zero.
- R13: Writes to offset 1 and to offset 7 change nothing. Offsets 3 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
Read data is combinational, so a wrong count, divider phase or reload choice shows on offset 1 in the cycle after the edge that caused it. The bench reads a register after every edge and compares it with a model, so an off-by-one reload or a missed wrap shows at most a few ticks later. A wrong divider phase shows as the count moving one tick early or late, which can take up to 256 cycles to appear. A lost or spurious expiry shows at `irq` and offset 4 at the next edge, and it stays visible because the flag is sticky.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Word offsets of the register map (decoded by the bus side)
  localparam int OFS_LOAD   = 0;
  localparam int OFS_VALUE  = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_ICLR   = 3;
  localparam int OFS_RAW    = 4;
  localparam int OFS_MASKED = 5;
  localparam int OFS_BGLOAD = 6;

  // Control word bit positions
  localparam int CTL_W      = 8;
  localparam int B_ONESHOT  = 0;
  localparam int B_WIDE     = 1;
  localparam int B_DIV_LO   = 2;
  localparam int B_IE       = 5;
  localparam int B_PERIODIC = 6;
  localparam int B_EN       = 7;

  localparam logic [CTL_W-1:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic       rsvd;
    logic [1:0] div_sel;
    logic       wide;
    logic       oneshot;
  } ctrl_t;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int SHIFT_MID  = 4,
  parameter int SHIFT_SLOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int PW = SHIFT_SLOW;

  // last phase value before a tick for each divider choice
  function automatic logic [PW-1:0] last_phase(input logic [1:0] sel);
    case (sel)
      2'b01:   last_phase = PW'((1 << SHIFT_MID) - 1);
      2'b10:   last_phase = PW'((1 << SHIFT_SLOW) - 1);
      default: last_phase = '0;
    endcase
  endfunction

  logic [PW-1:0] phase_q;

  assign tick = enable && !restart && (phase_q == last_phase(div_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      phase_q <= '0;
    else if (!enable || restart || tick) phase_q <= '0;
    else                             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cdt_downcount.sv
module cdt_downcount #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  input  logic             wide,
  input  logic             oneshot,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_eff,
  output logic             expiry
);
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic w);
    fit = w ? v : (v & NARROW_MASK);
  endfunction

  // value after one tick, given the visible count
  function automatic logic [CNT_W-1:0] after_tick(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] lim,
    input logic w, input logic os, input logic per);
    if (cur != '0)          after_tick = cur - 1'b1;
    else if (os)            after_tick = '0;
    else if (per)           after_tick = fit(lim, w);
    else                    after_tick = fit('1, w);
  endfunction

  logic [CNT_W-1:0] count_q;

  assign count_eff = fit(count_q, wide);
  assign expiry    = tick && !load_wr && (count_eff == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (load_wr) count_q <= load_val;
    else if (tick)    count_q <= after_tick(count_eff, limit, wide, oneshot, periodic);
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int DATA_W     = 32,
  parameter int NARROW_W   = 16,
  parameter int ADDR_W     = 3,
  parameter int SHIFT_MID  = 4,
  parameter int SHIFT_SLOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import cdt_pkg::*;

  logic [CTL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0] limit_q;
  logic              raw_q;
  logic              tick, expiry;
  logic [DATA_W-1:0] count_eff;
  ctrl_t             cf;

  assign cf = ctrl_t'(ctrl_q);

  logic wr_load, wr_ctrl, wr_iclr, wr_bg;
  assign wr_load = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_iclr = bus_we && (bus_addr == ADDR_W'(OFS_ICLR));
  assign wr_bg   = bus_we && (bus_addr == ADDR_W'(OFS_BGLOAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ctrl)          ctrl_q  <= bus_wdata[CTL_W-1:0];
      if (wr_load || wr_bg) limit_q <= bus_wdata;
      if (expiry)           raw_q   <= 1'b1;
      else if (wr_iclr)     raw_q   <= 1'b0;
    end
  end

  cdt_prescale #(.SHIFT_MID(SHIFT_MID), .SHIFT_SLOW(SHIFT_SLOW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cf.en),
    .restart (wr_ctrl),
    .div_sel (cf.div_sel),
    .tick    (tick)
  );

  cdt_downcount #(.CNT_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_wr   (wr_load),
    .load_val  (bus_wdata),
    .limit     (limit_q),
    .wide      (cf.wide),
    .oneshot   (cf.oneshot),
    .periodic  (cf.periodic),
    .count_eff (count_eff),
    .expiry    (expiry)
  );

  assign irq = raw_q && cf.ie;

  always_comb begin
    case (int'(bus_addr))
      OFS_LOAD, OFS_BGLOAD: bus_rdata = limit_q;
      OFS_VALUE:            bus_rdata = count_eff;
      OFS_CTRL:             bus_rdata = DATA_W'(ctrl_q);
      OFS_RAW:              bus_rdata = DATA_W'(raw_q);
      OFS_MASKED:           bus_rdata = DATA_W'(raw_q && cf.ie);
      default:              bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic              expiry,
  input logic [DATA_W-1:0] count_eff,
  input logic              raw_q,
  input logic [7:0]        ctrl_q,
  input logic              wr_load,
  input logic              wr_ctrl,
  input logic              wr_iclr
);
  localparam logic [DATA_W-1:0] LOWMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  a_r10_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> raw_q);

  a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && !expiry) |=> !raw_q);

  a_r11_masked_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(5)) |-> (bus_rdata == DATA_W'(irq)));

  a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_q[7]);

  a_r4_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !wr_load && !wr_ctrl) |=> $stable(count_eff));

  a_r7_oneshot_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[0] && count_eff == '0 && !wr_load && !wr_ctrl) |=> (count_eff == '0));

  a_r8_load_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (count_eff == (ctrl_q[1] ? $past(bus_wdata) : ($past(bus_wdata) & LOWMASK))));

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && bus_addr == ADDR_W'(1)) |-> ((bus_rdata & ~LOWMASK) == '0));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .tick      (tick),
  .expiry    (expiry),
  .count_eff (count_eff),
  .raw_q     (raw_q),
  .ctrl_q    (ctrl_q),
  .wr_load   (wr_load),
  .wr_ctrl   (wr_ctrl),
  .wr_iclr   (wr_iclr)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  cdt_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // ---------------- reference model ----------------
  logic [7:0]  m_ctrl;
  logic [31:0] m_limit, m_cnt;
  int          m_pre;
  bit          m_raw;

  function automatic logic [31:0] m_view(input logic [31:0] v, input logic [7:0] c);
    return c[1] ? v : {16'h0000, v[15:0]};
  endfunction

  function automatic int m_period(input logic [1:0] s);
    if (s == 2'd1) return 16;
    if (s == 2'd2) return 256;
    return 1;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd6: return m_limit;
      3'd1:       return m_view(m_cnt, m_ctrl);
      3'd2:       return {24'h0, m_ctrl};
      3'd4:       return {31'h0, m_raw};
      3'd5:       return {31'h0, m_raw & m_ctrl[5]};
      default:    return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic        wc, tk, ex;
    logic [31:0] eff;
    if (!rst_n) begin
      m_ctrl = 8'h20; m_limit = '0; m_cnt = '0; m_pre = 0; m_raw = 1'b0;
    end else begin
      wc  = bus_we && bus_addr == 3'd2;
      tk  = m_ctrl[7] && !wc && (m_pre == m_period(m_ctrl[3:2]) - 1);
      m_pre = (!m_ctrl[7] || wc || tk) ? 0 : m_pre + 1;
      eff = m_view(m_cnt, m_ctrl);
      ex  = 1'b0;
      if (bus_we && bus_addr == 3'd0) begin
        m_cnt = bus_wdata; m_limit = bus_wdata;
      end else begin
        if (tk) begin
          if (eff == 32'd1) ex = 1'b1;
          if (eff != 0)          m_cnt = eff - 1;
          else if (m_ctrl[0])    m_cnt = 0;
          else if (m_ctrl[6])    m_cnt = m_view(m_limit, m_ctrl);
          else                   m_cnt = m_view(32'hFFFF_FFFF, m_ctrl);
        end
        if (bus_we && bus_addr == 3'd6) m_limit = bus_wdata;
      end
      if (wc) m_ctrl = bus_wdata[7:0];
      if (ex) m_raw = 1'b1;
      else if (bus_we && bus_addr == 3'd3) m_raw = 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R8 load readback";
      3'd1: return "R4 count";
      3'd2: return "R2 control";
      3'd4: return "R11 raw flag";
      3'd5: return "R11 masked flag";
      3'd6: return "R9 deferred readback";
      default: return "R13 unmapped read";
    endcase
  endfunction

  // one bus cycle, then compare read data and irq against the model
  task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d);
    bus_addr = a; bus_we = w; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    expect_eq(tag_of(a), bus_rdata, m_read(a));
    expect_eq("R11 irq", {31'h0, irq}, {31'h0, m_raw & m_ctrl[5]});
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input logic [31:0] exp);
    bus_addr = a; bus_we = 1'b0;
    #0.5;
    expect_eq(tag, bus_rdata, exp);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd2, "R1 control reset", 32'h20);
    peek(3'd1, "R1 count reset", 32'h0);
    peek(3'd0, "R1 limit reset", 32'h0);
    peek(3'd4, "R1 raw reset", 32'h0);
    expect_eq("R1 irq reset", {31'h0, irq}, 32'h0);

    // R5: free-running 16-bit wraps to 0xFFFF, R10 flag set on 1->0
    step(3'd0, 1'b1, 32'd2);
    step(3'd2, 1'b1, 32'h80);
    step(3'd1, 1'b0, 0);
    step(3'd1, 1'b0, 0);
    step(3'd1, 1'b0, 0);
    peek(3'd1, "R5 wrap 16-bit", 32'h0000_FFFF);
    peek(3'd4, "R10 raw after expiry", 32'h1);
    peek(3'd5, "R11 masked with ie off", 32'h0);
    step(3'd3, 1'b1, 32'h0);
    peek(3'd4, "R10 raw cleared", 32'h0);

    // R7: one-shot 32-bit stops at zero
    step(3'd2, 1'b1, 32'h0);
    step(3'd0, 1'b1, 32'd3);
    step(3'd2, 1'b1, 32'hA3);
    for (int i = 0; i < 6; i++) step(3'd1, 1'b0, 0);
    peek(3'd1, "R7 one-shot holds zero", 32'h0);
    expect_eq("R11 irq with ie on", {31'h0, irq}, 32'h1);

    // R13: write to count and to offset 7 ignored
    step(3'd1, 1'b1, 32'hDEAD_BEEF);
    peek(3'd1, "R13 count write ignored", 32'h0);
    step(3'd7, 1'b1, 32'hFFFF_FFFF);
    peek(3'd7, "R13 offset 7 reads zero", 32'h0);
    peek(3'd2, "R13 control untouched", 32'hA3);

    // R9 / R6: deferred reload, periodic
    step(3'd3, 1'b1, 0);
    step(3'd2, 1'b1, 32'h0);
    step(3'd0, 1'b1, 32'd4);
    step(3'd2, 1'b1, 32'hE2);
    step(3'd6, 1'b1, 32'd10);
    peek(3'd1, "R9 deferred keeps count", 32'd3);
    peek(3'd0, "R9 load offset shows new value", 32'd10);
    for (int i = 0; i < 4; i++) step(3'd1, 1'b0, 0);
    peek(3'd1, "R6 periodic reload", 32'd10);

    // R8: immediate load while running wins over the tick
    step(3'd0, 1'b1, 32'd7);
    peek(3'd1, "R8 immediate load", 32'd7);

    // R3: divide-by-16
    step(3'd2, 1'b1, 32'h0);
    step(3'd0, 1'b1, 32'd5);
    step(3'd2, 1'b1, 32'h86);
    for (int i = 0; i < 15; i++) step(3'd1, 1'b0, 0);
    peek(3'd1, "R3 no tick before 16 cycles", 32'd5);
    step(3'd1, 1'b0, 0);
    peek(3'd1, "R3 tick at 16 cycles", 32'd4);

    // R12: 16-bit view, R4: hold while disabled, R2 readback
    step(3'd2, 1'b1, 32'h0);
    step(3'd0, 1'b1, 32'h1234_5678);
    for (int i = 0; i < 5; i++) step(3'd1, 1'b0, 0);
    peek(3'd1, "R12 16-bit view / R4 hold", 32'h0000_5678);
    peek(3'd0, "R12 limit full width", 32'h1234_5678);
    step(3'd2, 1'b1, 32'hFFFF_FF5B);
    peek(3'd2, "R2 control readback", 32'h5B);

    // R10: expiry and clear in the same cycle -> flag stays
    step(3'd2, 1'b1, 32'h0);
    step(3'd3, 1'b1, 0);
    step(3'd0, 1'b1, 32'd2);
    step(3'd2, 1'b1, 32'hA3);
    step(3'd1, 1'b0, 0);
    step(3'd3, 1'b1, 0);
    peek(3'd4, "R10 set wins over clear", 32'h1);

    // constrained random against the model
    for (int n = 0; n < 12000; n++) begin
      int op = int'($urandom % 16);
      logic [31:0] v;
      if (op < 10) step(3'($urandom % 8), 1'b0, 0);
      else if (op < 12) begin
        v = ($urandom % 8 == 0) ? $urandom : ($urandom % 48);
        step(($urandom % 2) ? 3'd0 : 3'd6, 1'b1, v);
      end else if (op < 14) begin
        v = $urandom;
        if ($urandom % 4 != 0) v[3:2] = 2'($urandom % 2);
        if ($urandom % 5 != 0) v[7] = 1'b1;
        step(3'd2, 1'b1, v);
      end else if (op == 14) step(3'd3, 1'b1, $urandom);
      else step(($urandom % 2) ? 3'd1 : 3'd7, 1'b1, $urandom);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule